// File: doc/BRIEF.md
# Convolutional Interleaver with Deinterleave Mode

This block spreads a stream of symbols over time by dealing them, one at a time, into a ring of branches. Each branch is a delay line, and the lengths of the lines grow by a fixed step from one branch to the next. An input arm and an output arm rotate together. Each valid symbol enters the selected branch, and the symbol that leaves that branch goes out. The arm then moves on to the next branch. Burst errors on the channel between an interleaver and its matching deinterleaver therefore end up scattered across many code words.

A single input selects the direction. In interleave mode branch `i` delays by `i*STEP` of its own visits, so branch 0 passes symbols straight through. In deinterleave mode the order of the lengths is reversed. Branch 0 then has the longest line, `(BRANCHES-1)*STEP`, and the last branch has none. An interleaver followed by a deinterleaver with the same parameters gives back the original sequence, delayed by a fixed number of symbols. The mode is expected to stay constant between resets.

Top module: `conv_interleaver`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears every delay line to zero, drives `out_valid` and `out_sym` to zero, and returns the arm to branch 0. The first valid symbol after reset therefore goes to branch 0.
- R2: The arm moves forward by exactly one branch for each cycle in which `in_valid` is high. After branch `BRANCHES-1` it wraps to branch 0.
- R3: When `mode_deint` is 0, let `n` count valid inputs from 0 after reset. The symbol output for input `n` is the input with index `n - (n mod BRANCHES)*STEP*BRANCHES`, or zero if that index is negative.
- R4: When `mode_deint` is 1, the symbol output for valid input `n` is the input with index `n - (BRANCHES-1-(n mod BRANCHES))*STEP*BRANCHES`, or zero if that index is negative.
- R5: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low in the cycle after each cycle with `in_valid` low.
- R6: In a cycle with `in_valid` low, no delay line shifts and the arm stays where it is. Gaps in the input stream therefore do not change the results R3 and R4 give, when those results are counted in valid symbols.
- R7: An instance in mode 0 whose outputs feed an instance in mode 1 with the same parameters gives back the original stream. Valid output `m` of the second instance equals original input `m - (BRANCHES-1)*STEP*BRANCHES`, or zero if that index is negative.
- R8: After a cycle with `in_valid` low, `out_sym` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_deint | input | 1 | 0 selects interleave lengths, 1 selects reversed (deinterleave) lengths |
| in_valid | input | 1 | The symbol on `in_sym` is valid in this cycle |
| in_sym | input | WIDTH | Input symbol |
| out_valid | output | 1 | `out_sym` carries a new symbol (registered) |
| out_sym | output | WIDTH | Output symbol (registered) |

## Verification
The hardest case to reach from the ports is a symbol that has travelled to the far end of the longest line while the input stream stops and restarts. Several full rotations of the arm must pass, with gaps in between, before the line drains. The stimulus sends runs long enough to cover more than three times the largest delay, in both modes, with idle cycles inserted in a fixed pattern. The expected value for every output comes from the count of valid symbols alone. A second instance in reverse mode sits behind the device under test, so the round trip back to the original order is checked symbol by symbol, including the zeros flushed out at the start.

// File: rtl/conv_ilv_pkg.sv
// Package of shared definitions for the convolutional interleaver.
// It holds the direction encoding and the helpers that size the arm index.
// Assumes: at least one branch.
package conv_ilv_pkg;

    typedef enum logic {
        DIR_SPREAD  = 1'b0,
        DIR_RESTORE = 1'b1
    } ilv_dir_e;

    // Width of an index that selects one of `count` branches (never below 1).
    function automatic int unsigned sel_width(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    // Length of physical delay line `idx` for a length step of `step`.
    function automatic int unsigned line_depth(input int unsigned idx,
                                               input int unsigned step);
        return idx * step;
    endfunction

endpackage

// File: rtl/ilv_commutator.sv
// Arm position counter shared by the input and output sides.
// It moves one branch forward on each `advance` pulse and wraps at the last branch.
// Assumes: BRANCHES >= 1; synchronous active-low reset parks the arm on branch 0.
module ilv_commutator #(
    parameter int unsigned BRANCHES = 4,
    localparam int unsigned SEL_W   = conv_ilv_pkg::sel_width(BRANCHES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [SEL_W-1:0] arm
);

    localparam logic [SEL_W-1:0] LAST_ARM = SEL_W'(BRANCHES - 1);

    // Step the arm on each valid symbol, wrapping after the last branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= '0;
        end else if (advance) begin
            arm <= (arm == LAST_ARM) ? '0 : arm + SEL_W'(1);
        end
    end

    AST_ARM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        arm <= LAST_ARM);                                                  // R2
    AST_ARM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && arm == LAST_ARM) |=> arm == '0);                       // R2
    AST_ARM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && arm != LAST_ARM) |=> arm == $past(arm) + SEL_W'(1));   // R2
    AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(arm));                                        // R6

endmodule

// File: rtl/ilv_delay_line.sv
// Fixed-length symbol shift register for one physical branch.
// It shifts only when enabled; `dout` is the oldest stored symbol.
// Assumes: DEPTH >= 1 (branches with zero delay are bypassed by the parent).
module ilv_delay_line #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [DEPTH];

    // Clear on reset; otherwise push a symbol in and age the rest by one place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++) stage[k] <= '0;
        end else if (shift_en) begin
            stage[0] <= din;
            for (int k = 1; k < int'(DEPTH); k++) stage[k] <= stage[k-1];
        end
    end

    assign dout = stage[DEPTH-1];

    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dout));                                      // R6

endmodule

// File: rtl/conv_interleaver.sv
// Convolutional interleaver/deinterleaver, top level.
// Physical line j has length j*STEP. The arm selects branch i; in spread mode
// branch i uses line i, in restore mode it uses line BRANCHES-1-i. The output
// is registered, so data appears one cycle after the valid input.
// Assumes: mode_deint is held constant between resets.
module conv_interleaver #(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned BRANCHES = 4,
    parameter int unsigned STEP     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_deint,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_sym,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sym
);

    import conv_ilv_pkg::*;

    localparam int unsigned SEL_W = sel_width(BRANCHES);
    localparam logic [SEL_W-1:0] LAST_ARM = SEL_W'(BRANCHES - 1);

    ilv_dir_e          dir;
    logic [SEL_W-1:0]  arm;
    logic [SEL_W-1:0]  line_sel;
    logic [WIDTH-1:0]  tail [BRANCHES];
    logic [WIDTH-1:0]  picked;

    assign dir = ilv_dir_e'(mode_deint);

    ilv_commutator #(.BRANCHES(BRANCHES)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .arm     (arm)
    );

    // Map the arm branch to a physical line; restore mode reverses the order.
    always_comb begin
        line_sel = (dir == DIR_RESTORE) ? (LAST_ARM - arm) : arm;
    end

    for (genvar j = 0; j < int'(BRANCHES); j++) begin : g_line
        if (j == 0) begin : g_bypass
            assign tail[j] = in_sym;
        end else begin : g_delay
            ilv_delay_line #(
                .WIDTH (WIDTH),
                .DEPTH (line_depth(j, STEP))
            ) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (in_valid && (line_sel == SEL_W'(j))),
                .din      (in_sym),
                .dout     (tail[j])
            );
        end
    end

    // Output arm: pick the symbol leaving the selected line.
    always_comb begin
        picked = '0;
        for (int j = 0; j < int'(BRANCHES); j++) begin
            if (line_sel == SEL_W'(j)) picked = tail[j];
        end
    end

    // Output register: flag follows the input strobe, data held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sym <= picked;
        end
    end

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                           // R5
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                         // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sym));                                   // R8
    AST_BYPASS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && line_sel == '0) |=> out_sym == $past(in_sym));        // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sym == '0));                         // R1

endmodule

// File: tb/conv_interleaver_test.sv
module conv_interleaver_test;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int B   = 4;
    localparam int L   = 2;
    localparam int RTD = (B - 1) * L * B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sym = '0;
    logic         out_valid;
    logic [W-1:0] out_sym;
    logic         back_valid;
    logic [W-1:0] back_sym;

    int           checks = 0;
    int           fails = 0;
    int           nsent = 0;
    int           nback = 0;
    bit           casc_on = 1'b0;
    bit           done = 1'b0;
    logic [W-1:0] last_out = '0;
    logic [W-1:0] hist [0:511];

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_interleaver #(.WIDTH(W), .BRANCHES(B), .STEP(L)) uut (
        .clk(clk), .rst_n(rst_n), .mode_deint(mode),
        .in_valid(in_valid), .in_sym(in_sym),
        .out_valid(out_valid), .out_sym(out_sym)
    );

    conv_interleaver #(.WIDTH(W), .BRANCHES(B), .STEP(L)) back_stage (
        .clk(clk), .rst_n(rst_n), .mode_deint(1'b1),
        .in_valid(out_valid), .in_sym(out_sym),
        .out_valid(back_valid), .out_sym(back_sym)
    );

    function automatic logic [W-1:0] expect_sym(int n, logic m);
        int br = n % B;
        int d  = m ? (B - 1 - br) * L : br * L;
        int ix = n - d * B;
        return (ix >= 0) ? hist[ix] : '0;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_sym = '0;
        repeat (2) @(negedge clk);
        // R1: outputs cleared after reset edges
        check("R1 out_valid", W'(out_valid), '0);
        check("R1 out_sym", out_sym, '0);
        rst_n = 1'b1;
        nsent = 0; nback = 0; last_out = '0;
    endtask

    task automatic send(bit v, logic [W-1:0] d);
        @(negedge clk);
        in_valid = v; in_sym = d;
        if (v) hist[nsent] = d;
        @(posedge clk);
        #1;
        if (v) begin
            check("R5 out_valid high", W'(out_valid), W'(1));
            // R2 R6: branch taken from the count of valid symbols only
            check(mode ? "R4 deinterleave symbol" : "R3 interleave symbol",
                  out_sym, expect_sym(nsent, mode));
            nsent++;
            last_out = out_sym;
        end else begin
            check("R5 out_valid low", W'(out_valid), '0);
            check("R8 hold", out_sym, last_out);
        end
        if (casc_on && back_valid) begin
            check("R7 round trip", back_sym,
                  (nback - RTD >= 0) ? hist[nback - RTD] : '0);
            nback++;
        end
    endtask

    task automatic run(int count, int seed, int gap_mod);
        for (int n = 0; n < count; n++) begin
            if (gap_mod > 0 && (n % gap_mod) == gap_mod - 1) send(1'b0, 8'hEE);
            send(1'b1, W'(((n * 37 + seed) % 255) + 1));
        end
    endtask

    initial begin
        do_reset();
        // R3 continuous stream, covers R2 wrap many times
        mode = 1'b0; do_reset(); run(110, 5, 0);
        // R3 R6 R8 gapped stream
        mode = 1'b0; do_reset(); run(110, 91, 3);
        // R4 gapped stream in reversed mode
        mode = 1'b1; do_reset(); run(110, 17, 4);
        // R7 interleave then deinterleave
        mode = 1'b0; do_reset(); casc_on = 1'b1;
        run(120, 43, 5);
        repeat (3) send(1'b0, '0);
        check("R7 count", W'(nback), W'(nsent));
        casc_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule